// File: doc/BRIEF.md
# UART Receiver with Break Wake-Up

This block is an asynchronous serial receiver for 8N1 frames with a 16x oversampling enable supplied from outside. In normal operation it finds a start bit, confirms it half a bit later, shifts in eight data bits LSB first, and checks the stop bit. The finished character goes into a single holding register, and the receive interrupt flag rises. A read strobe empties the register and clears the interrupt and both error flags. A receive-idle status tells software when no character and no break is in progress.

For low-power systems, software can arm a wake-up mode, but only while the receiver is idle. While armed, the receiver decodes nothing. The first falling edge on the line raises the receive interrupt. The rising edge that ends the break then clears the arm bit in hardware and returns the receiver to idle, with no data loaded. A sleep input gates a combinational wake output taken straight from the raw line, so that the output can restart a stopped clock.

Top module: `uart_wake_rx`

## Requirements
- R1: Reset clears the arm bit, the interrupt flag, the framing and overrun flags and the holding register, and drives rx_idle high.
- R2: An 8N1 frame (start bit 0, data LSB first, stop bit 1, 16 ticks per bit) loads its byte into rd_data and sets rx_int, with frame_err low.
- R3: A low pulse on rx that is high again at the start bit's mid-sample (sample 8) is rejected: no character, rx_int stays low, rx_idle returns high.
- R4: A frame whose stop bit is sampled low still loads its byte and sets frame_err.
- R5: A frame that completes while the register holds an unread byte sets overrun_err and leaves rd_data unchanged.
- R6: A one-cycle rd_strobe clears rx_int, frame_err and overrun_err.
- R7: rx_idle is low while a character is being received and while an armed break is in progress.
- R8: A pulse on wue_wr copies wue_wdata into the arm bit only when rx_idle is high; otherwise the write is ignored.
- R9: While armed, a falling edge on rx sets rx_int and leaves rd_data and the error flags unchanged.
- R10: The rising edge that ends an armed break clears the arm bit and returns rx_idle high, and the next frame is received normally.
- R11: wake is high exactly while sleep is high, the arm bit is set and the raw rx pin is low, with no clock edge in the path.
- R12: If the wake character is not all zeros, the arm bit clears at its first rising edge and the low bits that follow start a new, fragmented reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rx | input | 1 | Serial line, idle high |
| sleep | input | 1 | System is in sleep; enables the wake output |
| wue_wr | input | 1 | Write strobe for the arm bit |
| wue_wdata | input | 1 | Value written to the arm bit |
| rd_strobe | input | 1 | Read of the holding register |
| rd_data | output | 8 | Holding register contents |
| rx_int | output | 1 | Receive interrupt flag |
| wake | output | 1 | Combinational wake request while sleeping |
| wue | output | 1 | Arm bit for break wake-up |
| rx_idle | output | 1 | No reception or break in progress |
| frame_err | output | 1 | Stop bit was sampled low |
| overrun_err | output | 1 | A byte was lost because the register was full |

## Verification
The assertions assume that rx moves only at bit boundaries, at least several clock cycles apart, so a rising edge seen through the synchronizer reflects a line that was really high. They also assume that a read strobe does not land in the same cycle as a character completing or a wake edge, since those set the flags that the read clears. The bench drives rx one level per full bit time, 16 cycles with a tick every cycle. It places reads and arm writes only between frames, apart from the one arm write that is deliberately issued in the middle of a character.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP
    } fr_state_e;

    typedef struct packed {
        logic armed;
        logic in_break;
        logic irq;
        logic full;
        logic ferr;
        logic ovr;
    } wake_ctl_t;

endpackage

// File: rtl/uart_wake_sync.sv
module uart_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_s_o,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], rx_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign rx_s_o = sh_q[STAGES-1];
    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
    assign rise_o = ~sh_q[STAGES] & sh_q[STAGES-1];
endmodule

// File: rtl/uart_wake_frame.sv
module uart_wake_frame
    import uart_wake_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              rx_s_i,
    output logic              done_o,
    output logic              stop_bad_o,
    output logic [DATA_W-1:0] data_o,
    output logic              idle_o
);
    localparam int CW  = $clog2(OVS);
    localparam int BW  = $clog2(DATA_W + 1);
    localparam int MID = OVS / 2 - 1;

    typedef struct packed {
        fr_state_e         st;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     nbit;
        logic [DATA_W-1:0] shreg;
    } fr_reg_t;

    fr_reg_t q, d;
    logic    done_d;

    always_comb begin
        d      = q;
        done_d = 1'b0;
        if (!en_i) begin
            d.st  = FR_IDLE;
            d.cnt = '0;
        end else if (tick_i) begin
            case (q.st)
                FR_IDLE: begin
                    if (!rx_s_i) begin
                        d.st  = FR_START;
                        d.cnt = '0;
                    end
                end
                FR_START: begin
                    if (q.cnt == CW'(MID)) begin
                        d.cnt  = '0;
                        d.nbit = '0;
                        d.st   = rx_s_i ? FR_IDLE : FR_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                FR_DATA: begin
                    if (q.cnt == CW'(OVS - 1)) begin
                        d.cnt   = '0;
                        d.shreg = {rx_s_i, q.shreg[DATA_W-1:1]};
                        if (q.nbit == BW'(DATA_W - 1)) d.st = FR_STOP;
                        else                           d.nbit = q.nbit + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (q.cnt == CW'(OVS - 1)) begin
                        done_d = 1'b1;
                        d.cnt  = '0;
                        d.st   = FR_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: FR_IDLE, cnt: '0, nbit: '0, shreg: '0};
        else        q <= d;
    end

    assign done_o     = done_d;
    assign stop_bad_o = ~rx_s_i;
    assign data_o     = q.shreg;
    assign idle_o     = (q.st == FR_IDLE);
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uart_wake_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx,
    input  logic              sleep,
    input  logic              wue_wr,
    input  logic              wue_wdata,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_int,
    output logic              wake,
    output logic              wue,
    output logic              rx_idle,
    output logic              frame_err,
    output logic              overrun_err
);
    logic              rx_s, fall, rise;
    logic              fr_done, fr_stop_bad, fr_idle;
    logic [DATA_W-1:0] fr_data;
    logic              wake_hit;

    wake_ctl_t         ctl_q, ctl_d;
    logic [DATA_W-1:0] data_q, data_d;

    uart_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx),
        .rx_s_o (rx_s),
        .fall_o (fall),
        .rise_o (rise)
    );

    uart_wake_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (~ctl_q.armed),
        .tick_i     (tick16),
        .rx_s_i     (rx_s),
        .done_o     (fr_done),
        .stop_bad_o (fr_stop_bad),
        .data_o     (fr_data),
        .idle_o     (fr_idle)
    );

    assign rx_idle  = fr_idle & ~ctl_q.in_break;
    assign wake_hit = ctl_q.armed & ~ctl_q.in_break & fall;

    always_comb begin
        ctl_d  = ctl_q;
        data_d = data_q;
        if (rd_strobe) begin
            ctl_d.irq  = 1'b0;
            ctl_d.full = 1'b0;
            ctl_d.ferr = 1'b0;
            ctl_d.ovr  = 1'b0;
        end
        if (wue_wr && rx_idle) ctl_d.armed = wue_wdata;
        if (wake_hit) begin
            ctl_d.in_break = 1'b1;
            ctl_d.irq      = 1'b1;
        end else if (ctl_q.in_break && rise) begin
            ctl_d.in_break = 1'b0;
            ctl_d.armed    = 1'b0;
        end
        if (fr_done) begin
            if (ctl_q.full && !rd_strobe) begin
                ctl_d.ovr = 1'b1;
            end else begin
                data_d     = fr_data;
                ctl_d.full = 1'b1;
                ctl_d.irq  = 1'b1;
                ctl_d.ferr = fr_stop_bad;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            data_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            data_q <= data_d;
        end
    end

    assign rd_data     = data_q;
    assign rx_int      = ctl_q.irq;
    assign wue         = ctl_q.armed;
    assign frame_err   = ctl_q.ferr;
    assign overrun_err = ctl_q.ovr;
    assign wake        = sleep & ctl_q.armed & ~rx;
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_s,
    input logic              wue,
    input logic              wue_wr,
    input logic              rx_int,
    input logic              rx_idle,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] rd_data,
    input logic              frame_err,
    input logic              overrun_err,
    input logic              fr_done,
    input logic              wake_hit,
    input logic              wake
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!wue && !rx_int && rx_idle && !frame_err && !overrun_err));

    a_r5_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> $stable(rd_data));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !fr_done && !wake_hit) |=> (!rx_int && !frame_err && !overrun_err));

    a_r7_busy_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_int) && wue) |-> !rx_idle);

    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wue_wr && !rx_idle && !wue) |=> !wue);

    a_r9_armed_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        wue |=> $stable(rd_data));

    a_r10_clear_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wue) && !$past(wue_wr)) |-> $past(rx_s));

    a_r11_wake_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> wue);
endmodule

bind uart_wake_rx uart_wake_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_s        (rx_s),
    .wue         (wue),
    .wue_wr      (wue_wr),
    .rx_int      (rx_int),
    .rx_idle     (rx_idle),
    .rd_strobe   (rd_strobe),
    .rd_data     (rd_data),
    .frame_err   (frame_err),
    .overrun_err (overrun_err),
    .fr_done     (fr_done),
    .wake_hit    (wake_hit),
    .wake        (wake)
);

// File: tb/uart_wake_rx_bench.sv
`timescale 1ns/1ps
module uart_wake_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       rx = 1'b1;
    logic       sleep = 1'b0;
    logic       wue_wr = 1'b0;
    logic       wue_wdata = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       rx_int, wake, wue, rx_idle, frame_err, overrun_err;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    uart_wake_rx u_uart_wake_rx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx(rx), .sleep(sleep),
        .wue_wr(wue_wr), .wue_wdata(wue_wdata), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rx_int(rx_int), .wake(wake), .wue(wue),
        .rx_idle(rx_idle), .frame_err(frame_err), .overrun_err(overrun_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_v, input bit probe);
        for (int i = 0; i < 10; i++) begin
            for (int c = 0; c < 16; c++) begin
                @(posedge clk); #1;
                rx = (i == 0) ? 1'b0 : (i == 9) ? stop_v : b[i-1];
                wue_wdata = 1'b1;
                wue_wr = probe && (i == 3) && (c == 0);
                if (probe && i == 3 && c == 0) begin
                    @(negedge clk);
                    chk(rx_idle == 1'b0, "R7 busy mid-frame", rx_idle, 0);
                end
            end
        end
        @(posedge clk); #1;
        rx = 1'b1;
        wue_wr = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read();
        @(posedge clk); #1 rd_strobe = 1'b1;
        @(posedge clk); #1 rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_wue(input logic v);
        @(posedge clk); #1 wue_wr = 1'b1; wue_wdata = v;
        @(posedge clk); #1 wue_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk(rx_int == 0, "R1 rx_int", rx_int, 0);
        chk(wue == 0, "R1 wue", wue, 0);
        chk(rx_idle == 1, "R1 rx_idle", rx_idle, 1);
        chk(frame_err == 0 && overrun_err == 0, "R1 errors", {frame_err, overrun_err}, 0);
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R2, R6: every byte value
        for (int v = 0; v < 256; v++) begin
            send_frame(8'(v), 1'b1, 1'b0);
            chk(rx_int == 1, "R2 rx_int set", rx_int, 1);
            chk(rd_data == 8'(v), "R2 rd_data", rd_data, v);
            chk(frame_err == 0, "R2 no framing error", frame_err, 0);
            do_read();
            chk(rx_int == 0, "R6 read clears rx_int", rx_int, 0);
        end

        // R7, R8: arm write while receiving is ignored
        send_frame(8'h3C, 1'b1, 1'b1);
        chk(wue == 0, "R8 busy write ignored", wue, 0);
        chk(rd_data == 8'h3C, "R7 frame still received", rd_data, 8'h3C);
        do_read();

        // R3: short glitch rejected
        @(posedge clk); #1 rx = 1'b0;
        repeat (4) @(posedge clk);
        #1 rx = 1'b1;
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(rx_int == 0, "R3 glitch no char", rx_int, 0);
        chk(rx_idle == 1, "R3 back to idle", rx_idle, 1);

        // R4: bad stop bit
        send_frame(8'h5A, 1'b0, 1'b0);
        chk(frame_err == 1, "R4 frame_err", frame_err, 1);
        chk(rd_data == 8'h5A, "R4 byte loaded", rd_data, 8'h5A);
        do_read();
        chk(frame_err == 0, "R6 read clears frame_err", frame_err, 0);

        // R5: overrun
        send_frame(8'h11, 1'b1, 1'b0);
        send_frame(8'h22, 1'b1, 1'b0);
        chk(overrun_err == 1, "R5 overrun set", overrun_err, 1);
        chk(rd_data == 8'h11, "R5 old byte kept", rd_data, 8'h11);
        do_read();
        chk(overrun_err == 0, "R6 read clears overrun", overrun_err, 0);

        // R8, R11, R9, R10: armed break while sleeping
        write_wue(1'b1);
        chk(wue == 1, "R8 idle write accepted", wue, 1);
        sleep = 1'b1;
        #1;
        chk(wake == 0, "R11 wake low while line high", wake, 0);
        @(posedge clk); #1 rx = 1'b0;
        #0.5;
        chk(wake == 1, "R11 wake follows line", wake, 1);
        repeat (208) @(posedge clk);
        @(negedge clk);
        chk(rx_int == 1, "R9 break raises rx_int", rx_int, 1);
        chk(rx_idle == 0, "R7 idle low during break", rx_idle, 0);
        chk(rd_data == 8'h11, "R9 no data loaded", rd_data, 8'h11);
        chk(frame_err == 0 && overrun_err == 0, "R9 no errors", {frame_err, overrun_err}, 0);
        chk(wue == 1, "R10 still armed while low", wue, 1);
        @(posedge clk); #1 rx = 1'b1;
        #0.5;
        chk(wake == 0, "R11 wake drops with line", wake, 0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(wue == 0, "R10 rising edge disarms", wue, 0);
        chk(rx_idle == 1, "R10 back to idle", rx_idle, 1);
        sleep = 1'b0;
        do_read();
        chk(rx_int == 0, "R6 read clears wake irq", rx_int, 0);
        send_frame(8'hC3, 1'b1, 1'b0);
        chk(rd_data == 8'hC3 && rx_int == 1, "R10 next frame received", rd_data, 8'hC3);
        do_read();

        // R12: non-zero wake character, R11 no wake when awake
        write_wue(1'b1);
        for (int i = 0; i < 10; i++) begin
            for (int c = 0; c < 16; c++) begin
                @(posedge clk); #1;
                rx = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : (i == 1);
                if (i == 0 && c == 1) chk(wake == 0, "R11 no wake when awake", wake, 0);
                if (i == 2 && c == 0) begin
                    @(negedge clk);
                    chk(wue == 0, "R12 first rise disarms", wue, 0);
                end
                if (i == 4 && c == 0) begin
                    @(negedge clk);
                    chk(rx_idle == 0, "R12 fragment reception", rx_idle, 0);
                end
            end
        end
        @(posedge clk); #1 rx = 1'b1;
        repeat (200) @(posedge clk);
        @(negedge clk);
        chk(rx_int == 1, "R12 flag after fragment", rx_int, 1);
        do_read();
        chk(rx_int == 0 && rx_idle == 1, "R12 clean after read", {rx_int, rx_idle}, 1);

        finished = 1'b1;
        report();
    end
endmodule